// File: doc/BRIEF.md
# Toggle-on-Write Interrupt Register Block

This block collects eight single-cycle hardware event pulses from a serial bus controller. Each pulse is latched into a status register. Each status bit is masked by a matching bit in an enable register. A global enable bit then gates the result onto one level-sensitive interrupt line. Software reaches the block through a plain 32-bit register port. The port has a write strobe, a byte offset and write data, and it returns combinational read data.

Writing the status register does not overwrite it. Every bit written as one flips. Software acknowledges a pending event by writing a one to it. Writing a one to a bit that is clear sets that bit, which raises an interrupt from software. A separate reset register returns the whole block to its reset state, but only when a fixed key is written to it.

Top module: `irq_hub`

## Requirements
- R1: After the asynchronous reset, the status, enable and global enable registers are all zero and `irq_o` is low.
- R2: The registers sit at these byte offsets: global enable 0x1C, status 0x20, enable 0x28, soft reset 0x40. A read of any other offset returns zero, and a write to any other offset changes nothing.
- R3: An event pulse on `evt_i[b]` sets status bit b at the next clock edge, whatever the enable bits hold. The status bits and the enable bits use the same positions:
  - bit 0 is lost arbitration;
  - bit 3 is receive FIFO full;
  - bit 4 is bus idle;
  - bits 1, 2 and 7 are transmit error, transmit FIFO empty and transmit FIFO half empty;
  - bit 5 is addressed as target, and bit 6 is no longer addressed as target.
- R4: A write to the status register inverts every bit written as one and keeps every bit written as zero. Writing one to a clear bit sets it.
- R5: If an event pulse and a status write hit the same bit in the same cycle, the bit ends at one.
- R6: A write to the enable register replaces all eight bits. Reading the enable register returns the value last written, zero-extended.
- R7: Only bit 31 of the global enable register is stored. Reading it returns 0x80000000 when the bit is set and 0 when it is clear.
- R8: `irq_o` is a register. In each cycle it takes the value global-enable AND (OR over all bits of status AND enable), computed from the register contents of the cycle before.
- R9: Writing exactly 0x0000000A to the soft reset offset clears status, enable, global enable and `irq_o` at the next edge. An event arriving in that same cycle is discarded. Any other value written there has no effect, and the offset always reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset of the register being accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt_i | input | 8 | Hardware event pulses, one per source |
| irq_o | output | 1 | Level-sensitive interrupt output |

## Verification
The hardest cases to reach from the ports are same-cycle collisions:
- an event pulse landing on a bit that a status write is toggling in that same cycle;
- an event pulse arriving together with a valid soft-reset key.

The stimulus builds these cases directly. It then runs a pseudo-random stretch in which event pulses and writes over the whole offset set overlap freely. The behavioural reference model settles each collision by the stated priority, and it compares both `rdata` and `irq_o` on every cycle.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned OFF_GIE   = 32'h1C;
  localparam int unsigned OFF_STS   = 32'h20;
  localparam int unsigned OFF_EN    = 32'h28;
  localparam int unsigned OFF_SRST  = 32'h40;
  localparam logic [DW-1:0] SRST_KEY = 32'h0000_000A;

  // next value of one status bit: hardware set dominates a software toggle
  function automatic logic f_sts_bit(input logic cur, input logic tgl, input logic hw);
    return hw | (cur ^ tgl);
  endfunction

  // level that the interrupt register samples
  function automatic logic f_pending(input logic [DW-1:0] sts, input logic [DW-1:0] en,
                                     input logic gie);
    return gie & (|(sts & en));
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tgl_en,
  input  logic [N-1:0] tgl_mask,
  input  logic [N-1:0] evt,
  output logic [N-1:0] sts
);
  import irq_hub_pkg::*;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic tgl_b;
    assign tgl_b = tgl_en & tgl_mask[b];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sts[b] <= 1'b0;
      else if (clr) sts[b] <= 1'b0;
      else          sts[b] <= f_sts_bit(sts[b], tgl_b, evt[b]);
    end
  end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  input  logic         gie_wr,
  input  logic         gie_wdata,
  output logic [N-1:0] en_q,
  output logic         gie_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else if (clr) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (en_wr)  en_q  <= en_wdata;
      if (gie_wr) gie_q <= gie_wdata;
    end
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] sts,
  input  logic [N-1:0] en,
  input  logic         gie,
  output logic         irq
);
  import irq_hub_pkg::*;

  logic lvl;
  assign lvl = f_pending(DW'(sts), DW'(en), gie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (clr) irq <= 1'b0;
    else          irq <= lvl;
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [N_SRC-1:0]  evt_i,
  output logic              irq_o
);
  import irq_hub_pkg::*;

  localparam logic [ADDR_W-1:0] A_GIE  = ADDR_W'(OFF_GIE);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFF_STS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(OFF_SRST);

  // named decode events, also observed by the checker
  logic sel_gie, sel_sts, sel_en, sel_srst, addr_hit;
  logic gie_wr, sts_wr, en_wr, srst_hit;
  logic [N_SRC-1:0] sts_q, en_q;
  logic gie_q;

  assign sel_gie  = (addr == A_GIE);
  assign sel_sts  = (addr == A_STS);
  assign sel_en   = (addr == A_EN);
  assign sel_srst = (addr == A_SRST);
  assign addr_hit = sel_gie | sel_sts | sel_en | sel_srst;

  assign gie_wr   = wr_en & sel_gie;
  assign sts_wr   = wr_en & sel_sts;
  assign en_wr    = wr_en & sel_en;
  assign srst_hit = wr_en & sel_srst & (wdata == SRST_KEY);

  irq_status_bank #(.N(N_SRC)) u_sts (
    .clk(clk), .rst_n(rst_n), .clr(srst_hit),
    .tgl_en(sts_wr), .tgl_mask(wdata[N_SRC-1:0]),
    .evt(evt_i), .sts(sts_q)
  );

  irq_enable_regs #(.N(N_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .clr(srst_hit),
    .en_wr(en_wr), .en_wdata(wdata[N_SRC-1:0]),
    .gie_wr(gie_wr), .gie_wdata(wdata[31]),
    .en_q(en_q), .gie_q(gie_q)
  );

  irq_out_stage #(.N(N_SRC)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(srst_hit),
    .sts(sts_q), .en(en_q), .gie(gie_q), .irq(irq_o)
  );

  always_comb begin
    rdata = '0;
    if (sel_gie)     rdata = {gie_q, 31'b0};
    else if (sel_sts) rdata = 32'(sts_q);
    else if (sel_en)  rdata = 32'(en_q);
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_hit,
  input logic              sel_gie,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [N_SRC-1:0]  evt_i,
  input logic              irq_o,
  input logic [N_SRC-1:0]  sts_q,
  input logic [N_SRC-1:0]  en_q,
  input logic              gie_q,
  input logic              sts_wr,
  input logic              en_wr,
  input logic              srst_hit
);
  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> rdata == 32'b0);

  // R7
  gie_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_gie |-> (rdata == 32'h8000_0000 || rdata == 32'b0));

  // R3
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i && !srst_hit) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  // R4
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && evt_i == '0 && !srst_hit) |=> sts_q == ($past(sts_q) ^ $past(wdata[N_SRC-1:0])));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && !srst_hit) |=> $stable(en_q));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_hit |=> irq_o == $past(gie_q && ((sts_q & en_q) != '0)));

  // R9
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hit |=> (sts_q == '0 && en_q == '0 && !gie_q && !irq_o));
endmodule

bind irq_hub irq_hub_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .sel_gie(sel_gie),
  .wdata(wdata), .rdata(rdata), .evt_i(evt_i), .irq_o(irq_o),
  .sts_q(sts_q), .en_q(en_q), .gie_q(gie_q), .sts_wr(sts_wr),
  .en_wr(en_wr), .srst_hit(srst_hit)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt_i = '0;
  logic        irq_o;

  int vectors = 0;
  int errs = 0;
  int cyc = 0;
  bit done = 0;
  string phase = "R1 reset";

  // behavioural reference state
  bit [7:0] m_sts, m_en;
  bit       m_gie, m_irq;

  always #2 clk = ~clk;

  irq_hub u_irq_hub (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_gie = 0; m_irq = 0;
    end else begin
      bit lvl;
      lvl = 0;
      for (int b = 0; b < 8; b++) if (m_gie && m_sts[b] && m_en[b]) lvl = 1;
      m_irq = lvl;
      if (wr_en && addr == 12'h40 && wdata == 32'd10) begin
        m_sts = 0; m_en = 0; m_gie = 0; m_irq = 0;
      end else begin
        for (int b = 0; b < 8; b++) begin
          if (evt_i[b]) m_sts[b] = 1;
          else if (wr_en && addr == 12'h20 && wdata[b]) m_sts[b] = !m_sts[b];
        end
        if (wr_en && addr == 12'h28) m_en = wdata[7:0];
        if (wr_en && addr == 12'h1C) m_gie = wdata[31];
      end
    end
  end

  function automatic bit [31:0] exp_rd(input bit [11:0] a);
    case (a)
      12'h1C:  return m_gie ? 32'h8000_0000 : 32'h0;
      12'h20:  return {24'h0, m_sts};
      12'h28:  return {24'h0, m_en};
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (rdata !== exp_rd(addr)) begin
        errs++;
        $display("FAIL %s rdata@%h actual=%h expected=%h", phase, addr, rdata, exp_rd(addr));
      end
      vectors++;
      if (irq_o !== m_irq) begin
        errs++;
        $display("FAIL %s irq_o actual=%b expected=%b", phase, irq_o, m_irq);
      end
    end
  end

  task automatic step(input bit w, input bit [11:0] a, input bit [31:0] d, input bit [7:0] e);
    @(posedge clk); #1;
    wr_en = w; addr = a; wdata = d; evt_i = e;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    bit [15:0] lfsr;
    bit [11:0] offs [6];
    offs = '{12'h1C, 12'h20, 12'h28, 12'h40, 12'h24, 12'h100};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: every register reads zero
    phase = "R1 reset";
    step(0, 12'h1C, 0, 0); step(0, 12'h20, 0, 0); step(0, 12'h28, 0, 0); step(0, 12'h40, 0, 0);
    // R3: events latch with enables off, polled
    phase = "R3 poll";
    step(0, 12'h20, 0, 8'h81); step(0, 12'h20, 0, 8'h18); step(0, 12'h20, 0, 0);
    // R4: toggle clears set bits and sets clear bits
    phase = "R4 toggle";
    step(1, 12'h20, 32'h0000_0011, 0); step(0, 12'h20, 0, 0);
    step(1, 12'h20, 32'hFFFF_FF42, 0); step(0, 12'h20, 0, 0);
    // R6: enable replace
    phase = "R6 enable";
    step(1, 12'h28, 32'hFFFF_FF0F, 0); step(0, 12'h28, 0, 0);
    step(1, 12'h28, 32'h0000_0040, 0); step(0, 12'h28, 0, 0);
    // R7: only bit 31 of global enable
    phase = "R7 gie";
    step(1, 12'h1C, 32'h7FFF_FFFF, 0); step(0, 12'h1C, 0, 0);
    step(1, 12'h1C, 32'h8000_0000, 0); step(0, 12'h1C, 0, 0);
    // R8: interrupt follows pending one cycle later
    phase = "R8 irq";
    step(0, 12'h20, 0, 0); step(0, 12'h20, 0, 0);
    step(1, 12'h20, 32'h40, 0); step(0, 12'h20, 0, 0); step(0, 12'h20, 0, 0);
    step(1, 12'h20, 32'h40, 0); step(0, 12'h20, 0, 0);
    step(1, 12'h1C, 32'h0, 0); step(0, 12'h1C, 0, 0);
    // R5: event and toggle on the same bit
    phase = "R5 collide";
    step(1, 12'h20, 32'h04, 8'h04); step(0, 12'h20, 0, 0);
    step(1, 12'h20, 32'h04, 8'h04); step(0, 12'h20, 0, 0);
    // R2: unmapped offsets
    phase = "R2 unmapped";
    step(1, 12'h24, 32'hFFFF_FFFF, 0); step(1, 12'h100, 32'hFFFF_FFFF, 0);
    step(0, 12'h24, 0, 0); step(0, 12'h20, 0, 0); step(0, 12'h28, 0, 0); step(0, 12'h1C, 0, 0);
    // R9: wrong keys ignored, right key clears, event dropped
    phase = "R9 softreset";
    step(1, 12'h28, 32'hFF, 0); step(1, 12'h1C, 32'h8000_0000, 0);
    step(1, 12'h40, 32'h0B, 0); step(1, 12'h40, 32'h1A, 0); step(0, 12'h20, 0, 0);
    step(0, 12'h40, 0, 0);
    step(1, 12'h40, 32'h0A, 8'hFF); step(0, 12'h20, 0, 0); step(0, 12'h28, 0, 0);
    // mixed pseudo-random traffic, R3 R4 R5 R8 R9 interplay
    phase = "R8 random";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      bit [31:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = {lfsr[0], 23'h0, lfsr[15:8]};
      if (lfsr[3:0] == 4'h5) d = 32'h0A;
      step(lfsr[7], offs[lfsr[6:4] % 6], d, (lfsr[2:0] == 3'b0) ? lfsr[13:6] : 8'h0);
    end
    step(0, 12'h20, 0, 0); step(0, 12'h20, 0, 0);
    @(posedge clk); #1;
    finish_run();
  end
endmodule